// File: doc/BRIEF.md
# I2C Bus State and Error Monitor

This block watches the clock and data lines of a two-wire serial bus from the point of view of one host. Both lines are brought into the system clock domain through a short flop chain. The block then finds Start, repeated Start and Stop conditions on the sampled lines. From these it keeps a two-bit ownership state: unknown, idle, owned by this host, or busy with another host.

The host's transfer logic feeds in two intent signals. One says it is about to generate a Start. The other says it is leaving SDA released because it expects the line high, which it does for a 1 data bit, a NACK, or the moment before it pulls SDA low for a Start. When a released SDA reads low while SCL is high, the block reports lost arbitration. It also counts SCL pulses inside each frame, so that a Stop or repeated Start arriving where no complete frame has ended is flagged as a bus error. Software can force the state to idle by writing the idle code. No other written value has any effect.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After a synchronous reset, `bus_state` is 0 (unknown) and both pulse outputs are 0. The state stays unknown while no condition or write occurs. The state codes are 0 unknown, 1 idle, 2 owner and 3 busy.
- R2: While `en` is low, `bus_state` is held at 0, and `bus_err` and `arb_lost` stay low whatever the lines or writes do.
- R3: A cycle with `sw_wr` high and `sw_wdata` equal to 1 sets the state to idle. A write of 0, 2 or 3 leaves the state unchanged.
- R4: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. An SDA edge while SCL is low is neither. A line change takes effect on `bus_state` on the third rising clock edge after it is applied (two synchroniser flops, then the state register).
- R5: A Stop sets the state to idle from any state.
- R6: A Start or repeated Start with `issue_start` high and `sda_release` low sets the state to owner. Any other Start sets it to busy.
- R7: Within a frame opened by a Start, a Stop or repeated Start is legal only when it ends a whole number of 9-bit groups, at least one of them. Otherwise `bus_err` pulses high for one cycle. A Start followed directly by a Stop or by a repeated Start is therefore an error.
- R8: When `sda_release` is high, SCL reads high and SDA reads low, `arb_lost` pulses high for one cycle at the onset of that mismatch. This covers a mismatch during a Start the host was about to issue.
- R9: Arbitration loss while the state is owner moves the state to busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| issue_start | input | 1 | Host is generating the next Start |
| sda_release | input | 1 | Host leaves SDA released and expects it high |
| sw_wr | input | 1 | Software write strobe for the state field |
| sw_wdata | input | 2 | Value written to the state field |
| bus_state | output | 2 | Ownership state: 0 unknown, 1 idle, 2 owner, 3 busy |
| bus_err | output | 1 | One-cycle protocol violation pulse |
| arb_lost | output | 1 | One-cycle arbitration loss pulse |

## Verification
Every written code is swept against each reachable state: unknown, busy and owner. This separates the single force-idle code from the three ignored ones. Frames are driven with a Start followed directly by a Stop, a Start followed directly by a repeated Start, a Stop or repeated Start partway through a 9-bit group, and legal ends after whole groups. These patterns tell the frame-boundary rule apart from plain Start/Stop detection. Arbitration is exercised with a released 1 bit that reads back high, with one that reads back low while owned, and with a Start that another host wins. This shows the mismatch rule and the owner-to-busy move separately. An SDA fall under low SCL and a cycle-exact latency probe pin down the condition definitions.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef enum logic [1:0] {
    BS_UNKNOWN = 2'd0,
    BS_IDLE    = 2'd1,
    BS_OWNER   = 2'd2,
    BS_BUSY    = 2'd3
  } bus_state_e;

  localparam logic [1:0] FORCE_IDLE_CODE = 2'd1;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_FRAME_BITS  = 9;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '1;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '1;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond #(
  parameter int unsigned FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic proto_err
);

  localparam int unsigned BW = $clog2(FRAME_BITS + 1);
  localparam logic [BW-1:0] LAST_POS = BW'(FRAME_BITS);
  localparam logic [BW-1:0] ONE_POS  = BW'(1);

  logic          scl_p, sda_p;
  logic          scl_rise;
  logic          in_frame, whole_seen;
  logic [BW-1:0] bitpos;
  logic          legal_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = ~scl_p & scl_s;
  assign start_ev = en & scl_p & scl_s & sda_p & ~sda_s;
  assign stop_ev  = en & scl_p & scl_s & ~sda_p & sda_s;

  // The SCL high phase that carries the Stop or repeated Start has already
  // advanced the counter, so a clean boundary shows position one.
  assign legal_end = whole_seen && (bitpos == ONE_POS);
  assign proto_err = in_frame & (start_ev | stop_ev) & ~legal_end;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      in_frame   <= 1'b0;
      whole_seen <= 1'b0;
      bitpos     <= '0;
    end else if (start_ev) begin
      in_frame   <= 1'b1;
      whole_seen <= 1'b0;
      bitpos     <= '0;
    end else if (stop_ev) begin
      in_frame   <= 1'b0;
      whole_seen <= 1'b0;
      bitpos     <= '0;
    end else if (scl_rise && in_frame) begin
      if (bitpos == LAST_POS) begin
        bitpos     <= ONE_POS;
        whole_seen <= 1'b1;
      end else begin
        bitpos <= bitpos + ONE_POS;
      end
    end
  end

endmodule

// File: rtl/i2cmon_arb.sv
module i2cmon_arb (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic scl_s,
  input  logic sda_s,
  input  logic sda_release,
  output logic arb_rise
);

  logic hit, hit_d;

  assign hit = en & sda_release & scl_s & ~sda_s;

  always_ff @(posedge clk) begin
    if (rst) hit_d <= 1'b0;
    else     hit_d <= hit;
  end

  assign arb_rise = hit & ~hit_d;

endmodule

// File: rtl/i2cmon_state.sv
module i2cmon_state
  import i2cmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       issue_start,
  input  logic       sda_release,
  input  logic       arb_rise,
  input  logic       sw_wr,
  input  logic [1:0] sw_wdata,
  output bus_state_e state_q
);

  logic force_idle;
  assign force_idle = sw_wr && (sw_wdata == FORCE_IDLE_CODE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q <= BS_UNKNOWN;
    end else if (force_idle) begin
      state_q <= BS_IDLE;
    end else if (stop_ev) begin
      state_q <= BS_IDLE;
    end else if (start_ev) begin
      state_q <= (issue_start && !sda_release) ? BS_OWNER : BS_BUSY;
    end else if (arb_rise && state_q == BS_OWNER) begin
      state_q <= BS_BUSY;
    end
  end

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned FRAME_BITS  = DEF_FRAME_BITS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       issue_start,
  input  logic       sda_release,
  input  logic       sw_wr,
  input  logic [1:0] sw_wdata,
  output logic [1:0] bus_state,
  output logic       bus_err,
  output logic       arb_lost
);

  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       start_ev, stop_ev, proto_err, arb_rise;
  bus_state_e state_q;
  logic       bus_err_q, arb_lost_q;

  i2cmon_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cmon_cond #(.FRAME_BITS(FRAME_BITS)) u_cond (
    .clk(clk), .rst(rst), .en(en), .scl_s(scl_s), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev), .proto_err(proto_err)
  );

  i2cmon_arb u_arb (
    .clk(clk), .rst(rst), .en(en), .scl_s(scl_s), .sda_s(sda_s),
    .sda_release(sda_release), .arb_rise(arb_rise)
  );

  i2cmon_state u_state (
    .clk(clk), .rst(rst), .en(en), .start_ev(start_ev), .stop_ev(stop_ev),
    .issue_start(issue_start), .sda_release(sda_release),
    .arb_rise(arb_rise), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .state_q(state_q)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bus_err_q  <= 1'b0;
      arb_lost_q <= 1'b0;
    end else begin
      bus_err_q  <= proto_err;
      arb_lost_q <= arb_rise;
    end
  end

  assign bus_state = state_q;
  assign bus_err   = bus_err_q;
  assign arb_lost  = arb_lost_q;

endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       sw_wr,
  input logic [1:0] sw_wdata,
  input logic [1:0] bus_state,
  input logic       bus_err,
  input logic       arb_lost,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       arb_rise
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (bus_state == 2'd0 && !bus_err && !arb_lost));

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (bus_state == 2'd0 && !bus_err && !arb_lost));

  p_force_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (en && sw_wr && sw_wdata == 2'd1) |=> (bus_state == 2'd1));

  p_ignored_write_r3: assert property (@(posedge clk) disable iff (rst)
    (en && sw_wr && sw_wdata != 2'd1 && !start_ev && !stop_ev && !arb_rise)
      |=> $stable(bus_state));

  p_stop_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (en && stop_ev && !sw_wr) |=> (bus_state == 2'd1));

  p_start_claims_r6: assert property (@(posedge clk) disable iff (rst)
    (en && start_ev && !sw_wr) |=> (bus_state == 2'd2 || bus_state == 2'd3));

  p_err_single_r7: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> !bus_err);

  p_arb_single_r8: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> !arb_lost);

  p_owner_to_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (en && arb_rise && bus_state == 2'd2 && !sw_wr && !start_ev && !stop_ev)
      |=> (bus_state == 2'd3));

endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
  .bus_state(bus_state), .bus_err(bus_err), .arb_lost(arb_lost),
  .start_ev(start_ev), .stop_ev(stop_ev), .arb_rise(arb_rise)
);

// File: tb/i2c_bus_monitor_test.sv
`timescale 1ns/1ps
module i2c_bus_monitor_test;

  localparam int PH = 4;

  logic       clk = 1'b0;
  logic       rst, en, scl_in, sda_in, issue_start, sda_release, sw_wr;
  logic [1:0] sw_wdata;
  logic [1:0] bus_state;
  logic       bus_err, arb_lost;

  int n_chk = 0, n_fail = 0, n_err = 0, n_arb = 0;

  always #10 clk = ~clk;

  i2c_bus_monitor uut (
    .clk(clk), .rst(rst), .en(en), .scl_in(scl_in), .sda_in(sda_in),
    .issue_start(issue_start), .sda_release(sda_release), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .bus_state(bus_state), .bus_err(bus_err),
    .arb_lost(arb_lost)
  );

  always @(negedge clk) begin
    if (bus_err)  n_err++;
    if (arb_lost) n_arb++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ph();
    repeat (PH) @(negedge clk);
  endtask

  task automatic lines(input logic c, input logic d);
    scl_in = c; sda_in = d; wait_ph();
  endtask

  task automatic do_start();  lines(1,1); lines(1,0); lines(0,0); endtask
  task automatic do_stop();   lines(0,0); lines(1,0); lines(1,1); endtask
  task automatic do_rstart(); lines(0,1); lines(1,1); lines(1,0); lines(0,0); endtask
  task automatic do_bit(input logic b); lines(0,b); lines(1,b); lines(0,b); endtask
  task automatic do_bits(input int n);
    for (int i = 0; i < n; i++) do_bit(i[0]);
  endtask

  task automatic write(input logic [1:0] v);
    sw_wr = 1'b1; sw_wdata = v; @(negedge clk);
    sw_wr = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic reach(input int st);
    if (st == 0) begin
      en = 1'b0; repeat (2) @(negedge clk); en = 1'b1; wait_ph();
    end else begin
      lines(1,1);
      issue_start = (st == 2); sda_release = 1'b0;
      do_start();
      issue_start = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e0, a0;
    rst = 1; en = 0; scl_in = 1; sda_in = 1; issue_start = 0;
    sda_release = 0; sw_wr = 0; sw_wdata = 0;
    repeat (5) @(negedge clk);
    chk("R1 reset state", bus_state, 0);
    chk("R1 reset err", bus_err, 0);
    chk("R1 reset arb", arb_lost, 0);
    rst = 0; en = 1; wait_ph();
    chk("R1 stays unknown", bus_state, 0);

    // Stop from unknown; an SDA fall under low SCL is not a Start
    lines(0,1); lines(0,0);
    chk("R4 no start while SCL low", bus_state, 0);
    lines(1,0); lines(1,1);
    chk("R5 stop to idle", bus_state, 1);

    // Latency probe with another host's Start
    sda_in = 0;
    repeat (2) @(negedge clk);
    chk("R4 not yet after two edges", bus_state, 1);
    @(negedge clk);
    chk("R4 change on third edge", bus_state, 3);
    wait_ph(); lines(0,0);
    e0 = n_err;
    do_bits(9); do_stop();
    chk("R7 legal stop no error", n_err - e0, 0);
    chk("R5 stop from busy", bus_state, 1);

    // Own Start, released 1 reads high, then lost
    issue_start = 1; sda_release = 0;
    do_start();
    issue_start = 0;
    chk("R6 own start owner", bus_state, 2);
    a0 = n_arb;
    sda_release = 1;
    do_bit(1);
    chk("R8 matching 1 no loss", n_arb - a0, 0);
    lines(0,0); lines(1,0);
    chk("R8 loss pulse", n_arb - a0, 1);
    chk("R9 owner to busy", bus_state, 3);
    sda_release = 0;
    lines(0,0);
    e0 = n_err;
    do_bits(7); do_stop();
    chk("R7 stop after nine bits", n_err - e0, 0);

    // Arbitration lost while about to issue a Start
    a0 = n_arb;
    issue_start = 1; sda_release = 1;
    lines(1,1); lines(1,0);
    chk("R8 loss at start", n_arb - a0, 1);
    chk("R6 foreign start busy", bus_state, 3);
    issue_start = 0; sda_release = 0;
    lines(0,0); do_bits(9); do_stop();

    // Bus error patterns
    e0 = n_err;
    lines(1,1); lines(1,0); lines(1,1);
    chk("R7 start then stop", n_err - e0, 1);
    chk("R5 idle after bad stop", bus_state, 1);
    e0 = n_err;
    do_start(); do_rstart();
    chk("R7 start then repeated start", n_err - e0, 1);
    e0 = n_err;
    do_bits(3); do_stop();
    chk("R7 stop mid group", n_err - e0, 1);
    e0 = n_err;
    do_start(); do_bits(9); do_rstart();
    chk("R7 legal repeated start", n_err - e0, 0);
    chk("R6 repeated start busy", bus_state, 3);
    do_bits(12); do_stop();
    chk("R7 stop inside second group", n_err - e0, 1);

    // Write sweep over reachable states
    for (int st = 0; st < 4; st++) begin
      if (st == 1) continue;
      for (int v = 0; v < 4; v++) begin
        reach(st);
        write(v[1:0]);
        chk($sformatf("R3 write %0d in state %0d", v, st), bus_state,
            (v == 1) ? 1 : st);
        if (st != 0) do_stop();
      end
    end

    // Disabled monitor
    en = 0; lines(1,1);
    chk("R2 disabled unknown", bus_state, 0);
    e0 = n_err; a0 = n_arb;
    lines(1,0); lines(1,1);
    write(2'd1);
    chk("R2 write ignored", bus_state, 0);
    sda_release = 1; lines(1,0); sda_release = 0; lines(1,1);
    chk("R2 no error", n_err - e0, 0);
    chk("R2 no loss", n_arb - a0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule